// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Sequencer

This block sits between a synchronous host port and an asynchronous fast-page-mode DRAM. The DRAM has 10 multiplexed address pins and an 8-bit data bus. Each host request carries a 20-bit byte address, a write flag and a write byte. The sequencer turns it into row-strobe, column-strobe and write-enable waveforms on the DRAM pins. The upper half of the address goes out as the row and the lower half as the column. Every interval between strobe edges is a whole number of system clock cycles, and each interval has its own parameter.

After an access the row is left open. A later request to the same row needs only a column strobe pulse, and reads and early writes can follow each other in any order. The row is closed first, with a full precharge, in three cases: the next request targets another row, a refresh arbiter asserts its hold, or the row has been open longer than a configurable cycle limit. Writes are always early writes. Write-enable goes low, and the data bus is driven, one cycle before the column strobe falls. Read data is sampled on the clock edge that raises the column strobe and is returned with a one-cycle valid pulse. Only one request is in flight at a time.

Top module: `dram_page_seq`

## Requirements
- R1: During and right after reset, rasN, casN and weN are high, dqOe and rdValid are low, and reqReady is high.
- R2: When rasN falls, dramAddr carries reqAddr[19:10] (row). When casN falls, dramAddr carries reqAddr[9:0] (column).
- R3: casN falls only while rasN is low. It falls at least RCD_CYC cycles after rasN fell, and stays low CAS_CYC cycles.
- R4: A write (reqWrite=1) is an early write. At the casN falling edge, weN is low, dqOe is high and dqOut holds the write byte. weN stays unchanged while casN is low. A later read of the same address returns that byte.
- R5: A read keeps weN high and returns, on rdData, the byte the DRAM drives while casN is low. rdValid is a single-cycle pulse. When the request is accepted with no row open, rdValid rises RCD_CYC+CAS_CYC+1 clock edges after the accepting edge.
- R6: A request to the open row, while no hold is pending and the limit has not run out, produces no rasN fall. A read of this kind returns rdValid CAS_CYC+1 edges after acceptance. Reads and writes may alternate freely within the open row.
- R7: A request to a different row first raises rasN, keeps it high at least RP_CYC cycles, and then opens the new row. A read of this kind returns rdValid RP_CYC+RCD_CYC+CAS_CYC+1 edges after acceptance.
- R8: While refHold is high, reqReady is low and any open row is closed. refGrant is high only while rasN and casN are both high and no access is in progress.
- R9: A row left open and idle for OPEN_LIMIT cycles, counted from the rasN fall, is closed. A later request to it opens it again from scratch.
- R10: dqOe is high only while weN is low.
- R11: reqReady is low from the accepting edge until the access has finished its column strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer can accept a request |
| reqAddr | input | 20 | Byte address: row in [19:10], column in [9:0] |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 8 | Write byte |
| rdValid | output | 1 | One-cycle pulse: rdData holds read result |
| rdData | output | 8 | Read result |
| refHold | input | 1 | Refresh arbiter asks for the DRAM |
| refGrant | output | 1 | DRAM is idle and precharged for the arbiter |
| dramAddr | output | 10 | Multiplexed row/column address pins |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| dqOut | output | 8 | Data driven toward the DRAM |
| dqOe | output | 1 | Enable for the dqOut tristate buffer |
| dqIn | input | 8 | Data coming back from the DRAM |

## Verification
The hardest state to reach is an open row whose time budget runs out while a hit is waiting. It takes a long idle spell, after a page burst, on a row that is still open. The limit test leaves the row untouched past OPEN_LIMIT cycles and checks that rasN has risen. It then sends a request to that same row and checks that it takes the full row-open latency, not the page-hit one. A second hard case is a row miss while the page is open. The bench first opens a page with mixed writes and reads, then sends a request to another row. It counts rasN falls and precharge cycles in its DRAM model, and measures the exact read latency.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RSET,
    S_ROWA,
    S_COLSET,
    S_CASL,
    S_CASHI,
    S_OPEN,
    S_PRE
  } seqState_t;

  typedef struct packed {
    logic load;
    logic rowLatch;
    logic colSel;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter int RCD_CYC    = 2,
  parameter int CAS_CYC    = 2,
  parameter int CP_CYC     = 1,
  parameter int RP_CYC     = 2,
  parameter int OPEN_LIMIT = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       rowHit,
  input  logic       refHold,
  output logic       reqReady,
  output logic       refGrant,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       dqOe,
  output dpStrobe_t  strobe
);

  localparam int MAXA = (RCD_CYC > CAS_CYC) ? RCD_CYC : CAS_CYC;
  localparam int MAXB = (CP_CYC > RP_CYC) ? CP_CYC : RP_CYC;
  localparam int MAXT = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int OW   = $clog2(OPEN_LIMIT + 1);

  seqState_t      state, nxt;
  logic [CW-1:0]  cnt, cntNxt;
  logic [OW-1:0]  openCnt;
  logic           pendQ, pendNxt;
  logic           wrQ, wrNext;
  logic           colSelQ;
  logic           accept, expired, rowOpenNxt;

  assign expired  = (openCnt >= OW'(OPEN_LIMIT));
  assign reqReady = !refHold && ((state == S_IDLE) || (state == S_OPEN && !expired));
  assign accept   = reqValid && reqReady;
  assign refGrant = (state == S_IDLE) && refHold;
  assign wrNext   = accept ? reqWrite : wrQ;

  always_comb begin
    nxt     = state;
    cntNxt  = (cnt == '0) ? '0 : cnt - 1'b1;
    pendNxt = pendQ;
    unique case (state)
      S_IDLE:   if (accept) nxt = S_RSET;
      S_RSET: begin
        nxt    = S_ROWA;
        cntNxt = CW'(RCD_CYC - 2);
      end
      S_ROWA:   if (cnt == '0) nxt = S_COLSET;
      S_COLSET: begin
        nxt    = S_CASL;
        cntNxt = CW'(CAS_CYC - 1);
      end
      S_CASL: if (cnt == '0) begin
        nxt    = S_CASHI;
        cntNxt = CW'(CP_CYC - 1);
      end
      S_CASHI:  if (cnt == '0) nxt = S_OPEN;
      S_OPEN: begin
        if (refHold || expired) begin
          nxt    = S_PRE;
          cntNxt = CW'(RP_CYC - 1);
        end else if (accept) begin
          if (rowHit) begin
            nxt = S_COLSET;
          end else begin
            nxt     = S_PRE;
            cntNxt  = CW'(RP_CYC - 1);
            pendNxt = 1'b1;
          end
        end
      end
      S_PRE: if (cnt == '0) begin
        nxt     = pendQ ? S_RSET : S_IDLE;
        pendNxt = 1'b0;
      end
      default:  nxt = S_IDLE;
    endcase
  end

  assign rowOpenNxt = (nxt == S_ROWA) || (nxt == S_COLSET) || (nxt == S_CASL) ||
                      (nxt == S_CASHI) || (nxt == S_OPEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      pendQ   <= 1'b0;
      wrQ     <= 1'b0;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      weN     <= 1'b1;
      dqOe    <= 1'b0;
      colSelQ <= 1'b0;
      openCnt <= '0;
    end else begin
      state   <= nxt;
      cnt     <= cntNxt;
      pendQ   <= pendNxt;
      if (accept) wrQ <= reqWrite;
      rasN    <= !rowOpenNxt;
      casN    <= !(nxt == S_CASL);
      weN     <= !(((nxt == S_COLSET) || (nxt == S_CASL)) && wrNext);
      dqOe    <= ((nxt == S_COLSET) || (nxt == S_CASL)) && wrNext;
      colSelQ <= (nxt == S_COLSET) || (nxt == S_CASL);
      if (state == S_RSET)
        openCnt <= '0;
      else if (!rasN && !expired)
        openCnt <= openCnt + 1'b1;
    end
  end

  assign strobe.load     = accept;
  assign strobe.rowLatch = (state == S_RSET);
  assign strobe.colSel   = colSelQ;
  assign strobe.capture  = (state == S_CASL) && (cnt == '0) && !wrQ;

  AST_OE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !weN) else $error("dqOe without weN low"); // R10
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN) else $error("casN low while rasN high"); // R3
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    refGrant |-> (rasN && casN && !reqReady)) else $error("grant while busy"); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !reqReady) else $error("ready during column cycle"); // R11
  AST_WE_STABLE_CAS: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && !$fell(casN)) |-> $stable(weN)) else $error("weN moved under casN"); // R4

  generate
    if (RP_CYC >= 2) begin : g_preChk
      AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rasN) |=> rasN) else $error("precharge too short"); // R7
    end
    if (CAS_CYC >= 2) begin : g_casChk
      AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
        $fell(casN) |=> !casN) else $error("casN pulse too short"); // R3
    end
  endgenerate

endmodule

// File: rtl/dram_page_dp.sv
module dram_page_dp
  import dram_page_pkg::*;
#(
  parameter int PIN_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [2*PIN_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    dqIn,
  output logic                 rowHit,
  output logic [PIN_W-1:0]     dramAddr,
  output logic [DATA_W-1:0]    dqOut,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData
);

  localparam int ADDR_W = 2 * PIN_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [PIN_W-1:0]  openRowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      openRowQ <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.rowLatch) openRowQ <= addrQ[ADDR_W-1:PIN_W];
      if (strobe.capture)  rdData   <= dqIn;
      rdValid <= strobe.capture;
    end
  end

  assign rowHit   = (reqAddr[ADDR_W-1:PIN_W] == openRowQ);
  assign dramAddr = strobe.colSel ? addrQ[PIN_W-1:0] : addrQ[ADDR_W-1:PIN_W];
  assign dqOut    = wdataQ;

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid) else $error("rdValid longer than one cycle"); // R5

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_page_pkg::*;
#(
  parameter int PIN_W      = 10,
  parameter int DATA_W     = 8,
  parameter int RCD_CYC    = 2,
  parameter int CAS_CYC    = 2,
  parameter int CP_CYC     = 1,
  parameter int RP_CYC     = 2,
  parameter int OPEN_LIMIT = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [2*PIN_W-1:0]   reqAddr,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 refHold,
  output logic                 refGrant,
  output logic [PIN_W-1:0]     dramAddr,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [DATA_W-1:0]    dqOut,
  output logic                 dqOe,
  input  logic [DATA_W-1:0]    dqIn
);

  dpStrobe_t strobe;
  logic      rowHit;

  dram_page_ctrl #(
    .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC), .CP_CYC(CP_CYC),
    .RP_CYC(RP_CYC), .OPEN_LIMIT(OPEN_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowHit(rowHit), .refHold(refHold), .reqReady(reqReady),
    .refGrant(refGrant), .rasN(rasN), .casN(casN), .weN(weN),
    .dqOe(dqOe), .strobe(strobe)
  );

  dram_page_dp #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .dqIn(dqIn), .rowHit(rowHit),
    .dramAddr(dramAddr), .dqOut(dqOut), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;

  localparam int RCD = 2, CASC = 2, CP = 1, RP = 2, LIM = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, refHold = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid, refGrant, rasN, casN, weN, dqOe;
  logic [7:0]  rdData, dqOut, dqIn, rdByte;
  logic [9:0]  dramAddr, rowM;

  int vecs = 0, fails = 0, protoErr = 0, rasFalls = 0;
  int cyc = 0, tRasRise = 0, tRasFall = 0;
  bit everRose = 0;
  logic [7:0] mem [logic [19:0]];

  always #10 clk = ~clk;

  dram_page_seq #(.RCD_CYC(RCD), .CAS_CYC(CASC), .CP_CYC(CP), .RP_CYC(RP),
    .OPEN_LIMIT(LIM)) u_dram_page_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .refHold(refHold), .refGrant(refGrant),
    .dramAddr(dramAddr), .rasN(rasN), .casN(casN), .weN(weN),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn));

  // DRAM model with protocol monitors
  always @(posedge clk) cyc = cyc + 1;
  always @(negedge rasN) begin
    rowM = dramAddr; rasFalls++; tRasFall = cyc;
    if (!casN) protoErr++;
    if (everRose && (cyc - tRasRise) < RP) protoErr++;
  end
  always @(posedge rasN) begin tRasRise = cyc; everRose = 1; end
  always @(negedge casN) begin
    if (rasN || (cyc - tRasFall) < RCD) protoErr++;
    if (!weN) begin
      if (!dqOe) protoErr++;
      mem[{rowM, dramAddr}] = dqOut;
    end
    rdByte = mem.exists({rowM, dramAddr}) ? mem[{rowM, dramAddr}] : 8'h00;
  end
  assign dqIn = (!casN && weN) ? rdByte : 8'hEE;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one host access; returns read byte and edges from accept to rdValid
  task automatic access(input logic [19:0] a, input logic wr, input logic [7:0] wd,
                        output logic [7:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    lat = 0; rd = '0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 ready low after accept", reqReady, 0);
    if (!wr) begin
      while (!rdValid && lat < 50) begin lat++; @(negedge clk); end
      rd = rdData;
    end
    while (casN == 1'b0 || !(reqReady || refHold)) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rasN", rasN, 1); chk("R1 casN", casN, 1); chk("R1 weN", weN, 1);
    chk("R1 dqOe", dqOe, 0); chk("R1 rdValid", rdValid, 0); chk("R1 ready", reqReady, 1);
  endtask

  task automatic t_idleRead();
    logic [7:0] rd; int lat; int f0;
    mem[20'h2B3C4] = 8'hA5; f0 = rasFalls;
    access(20'h2B3C4, 0, 8'h00, rd, lat);
    chk("R2 R5 read data", rd, 8'hA5);
    chk("R5 latency from idle", lat, RCD + CASC + 1);
    chk("R2 one row open", rasFalls - f0, 1);
    chk("R3 protocol", protoErr, 0);
  endtask

  task automatic t_pageMix();
    logic [7:0] rd; int lat; int f0;
    f0 = rasFalls;
    access(20'h2B3FF, 1, 8'h3C, rd, lat);
    chk("R4 write landed", mem[20'h2B3FF], 8'h3C);
    access(20'h2B3FF, 0, 8'h00, rd, lat);
    chk("R4 readback", rd, 8'h3C);
    chk("R6 hit latency", lat, CASC + 1);
    access(20'h2B001, 1, 8'h81, rd, lat);
    access(20'h2B002, 1, 8'h7E, rd, lat);
    access(20'h2B001, 0, 8'h00, rd, lat);
    chk("R6 mixed read 1", rd, 8'h81);
    access(20'h2B002, 0, 8'h00, rd, lat);
    chk("R6 mixed read 2", rd, 8'h7E);
    chk("R6 no new row", rasFalls - f0, 0);
    chk("R4 R10 protocol", protoErr, 0);
  endtask

  task automatic t_miss();
    logic [7:0] rd; int lat; int f0;
    mem[20'h0FF10] = 8'hC3; f0 = rasFalls;
    access(20'h0FF10, 0, 8'h00, rd, lat);
    chk("R7 miss data", rd, 8'hC3);
    chk("R7 miss latency", lat, RP + RCD + CASC + 1);
    chk("R7 reopened", rasFalls - f0, 1);
    chk("R7 precharge", protoErr, 0);
  endtask

  task automatic t_refresh();
    @(negedge clk); refHold = 1'b1;
    repeat (RP + 1) @(negedge clk);
    chk("R8 row closed", rasN, 1);
    chk("R8 grant", refGrant, 1);
    reqValid = 1'b1; reqAddr = 20'h0FF10; reqWrite = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 ready held low", reqReady, 0);
    chk("R8 rasN stays high", rasN, 1);
    reqValid = 1'b0; refHold = 1'b0;
    @(negedge clk);
    chk("R8 grant dropped", refGrant, 0);
  endtask

  task automatic t_limit();
    logic [7:0] rd; int lat; int f0;
    access(20'h0FF11, 1, 8'h5F, rd, lat);
    repeat (2) @(negedge clk);
    chk("R6 row still open", rasN, 0);
    repeat (LIM + 4) @(negedge clk);
    chk("R9 row closed by limit", rasN, 1);
    f0 = rasFalls;
    access(20'h0FF11, 0, 8'h00, rd, lat);
    chk("R9 data", rd, 8'h5F);
    chk("R9 full latency after close", lat, RCD + CASC + 1);
    chk("R9 row reopened", rasFalls - f0, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idleRead();
    t_pageMix();
    t_miss();
    t_refresh();
    t_limit();
    chk("R3 R7 final protocol", protoErr, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule